// File: doc/BRIEF.md
# ADC Result Buffer Sequencer

This block sits behind an analog-to-digital converter and manages where the finished conversion results go. Each result arrives with a valid strobe and is written into a 16-entry result memory. After a programmable number of results, the block raises a one-cycle interrupt so that software can collect a batch.

The memory can run in two ways. In linear mode it is one 16-word buffer. In ping-pong mode it is two 8-word halves that take turns. A fill-status flag tells software which half the hardware is writing, so software reads the other half.

For every sample, the block also tells the input-select logic which of two multiplexer setting sets (A or B) to use. It can alternate between the two sets from sample to sample. It also passes a scan-enable bit onward as a scan request. Software programs all of this through a single 16-bit control register. The buffer is read through a combinational read port.

Top module: `adc_result_sequencer`

## Requirements
- R1: After reset the control register reads 0x0000, `irq` is low, `mux_sel_b` is low (set A) and `scan_req` is low.
- R2: The control register has these fields:
  - bit 0: ping-pong mode.
  - bit 1: alternate mode.
  - bit 2: scan enable.
  - bits 7:4: interval N.
  - bit 8: fill status, read-only.

  All other bits read 0. For example, writing 0xFFFF reads back 0x00F7 while the lower half is being filled.
- R3: With interval field N, `irq` pulses once per N+1 accepted results. N=0 pulses on every result and N=15 pulses on every 16th.
- R4: `irq` is high only in the cycle that follows the clock edge that stored the last result of an interval.
- R5: In linear mode (bit 0 = 0), the k-th result of an interval (counting from 0) goes to address k. Every interval starts again at address 0x0.
- R6: In ping-pong mode (bit 0 = 1), an interval fills one 8-word half (0x0–0x7 or 0x8–0xF). The next interval fills the other half. If an interval holds more than 8 results, the pointer wraps within its half.
- R7: Fill status (bit 8) reads 0 while the lower half is filled and 1 while the upper half is filled. It flips at each interrupt in ping-pong mode and reads 0 in linear mode.
- R8: With alternate mode set, `mux_sel_b` starts at 0 (set A) and toggles after every accepted result. With it clear, `mux_sel_b` stays 0.
- R9: `scan_req` follows the scan-enable bit and changes only on a control write.
- R10: A control write clears the write pointer, the result counter, the A/B phase and the fill half. A result presented in the same cycle as a control write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read data including fill status |
| res_valid | input | 1 | Conversion result valid strobe |
| res_data | input | DW | Conversion result |
| rd_addr | input | 4 | Buffer read address |
| rd_data | output | DW | Buffer word at `rd_addr` |
| irq | output | 1 | Interval-complete pulse |
| mux_sel_b | output | 1 | 1 selects setting set B for the next sample |
| scan_req | output | 1 | Scan request to input-select logic |

## Verification
A vector table walks through several combinations of mode, interval and result count:
- single-result, mid-sized and full-16 intervals in linear mode;
- short, exactly-a-half and single-result intervals in ping-pong mode;
- an alternating, scanning configuration.

Comparing the interrupt count, the final fill flag and the address of the last result separates linear from ping-pong addressing. It also separates an N from an N+1 interval error.

Directed cases then check the reset values and the register read mask. They also cover a restart by reconfiguration in mid-interval, a result that collides with a control write, wrap within a half when the interval exceeds 8, and the A/B toggle sequence.

// File: rtl/adc_result_sequencer.sv
module adc_result_sequencer #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic [3:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          mux_sel_b,
  output logic          scan_req
);
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int HW    = AW - 1;

  logic          pp_mode, alt_mode, scan_en;
  logic [3:0]    interval;
  logic          half, phase;
  logic [AW-1:0] ptr;
  logic [3:0]    cnt;
  logic [DW-1:0] mem [DEPTH];

  logic          accept, last;
  logic [AW-1:0] wr_addr;

  assign accept    = res_valid & ~cfg_we;
  assign last      = accept & (cnt == interval);
  assign wr_addr   = pp_mode ? {half, ptr[HW-1:0]} : ptr;
  assign cfg_rdata = {7'd0, half & pp_mode, interval, 1'b0, scan_en, alt_mode, pp_mode};
  assign rd_data   = mem[rd_addr];
  assign mux_sel_b = alt_mode & phase;
  assign scan_req  = scan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_mode  <= 1'b0;
      alt_mode <= 1'b0;
      scan_en  <= 1'b0;
      interval <= '0;
      half     <= 1'b0;
      phase    <= 1'b0;
      ptr      <= '0;
      cnt      <= '0;
      irq      <= 1'b0;
    end else if (cfg_we) begin
      pp_mode  <= cfg_wdata[0];
      alt_mode <= cfg_wdata[1];
      scan_en  <= cfg_wdata[2];
      interval <= cfg_wdata[7:4];
      half     <= 1'b0;
      phase    <= 1'b0;
      ptr      <= '0;
      cnt      <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= last;
      if (accept) begin
        phase <= ~phase;
        if (last) begin
          ptr <= '0;
          cnt <= '0;
          if (pp_mode) half <= ~half;
        end else begin
          cnt <= cnt + 4'd1;
          ptr <= pp_mode ? {1'b0, ptr[HW-1:0] + 1'b1} : ptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_addr] <= res_data;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= interval);
  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(res_valid && !cfg_we));
  // R5
  ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ptr == '0 && cnt == '0));
  // R7
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && pp_mode) |-> (half != $past(half)));
  // R8
  alt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_valid && !cfg_we) && alt_mode) |-> (mux_sel_b != $past(mux_sel_b)));
  // R9
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(scan_req));
  // R10
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> (ptr == '0 && cnt == '0 && !mux_sel_b && !irq));
endmodule

// File: tb/adc_result_sequencer_bench.sv
`timescale 1ns/1ps
module adc_result_sequencer_bench;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic [3:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq, mux_sel_b, scan_req;

  adc_result_sequencer #(.DW(DW)) u_adc_result_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .res_valid(res_valid), .res_data(res_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .mux_sel_b(mux_sel_b), .scan_req(scan_req));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, irqs = 0;
  int seq = 0;
  bit done = 0;

  typedef struct packed {
    logic [15:0] cfg;
    logic [7:0]  n;
    logic [7:0]  irqs;
    logic        fill;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{16'h0000, 8'd5,  8'd5, 1'b0},
    '{16'h0030, 8'd10, 8'd2, 1'b0},
    '{16'h00F0, 8'd33, 8'd2, 1'b0},
    '{16'h0031, 8'd12, 8'd3, 1'b1},
    '{16'h0071, 8'd16, 8'd2, 1'b0},
    '{16'h0001, 8'd3,  8'd3, 1'b1},
    '{16'h0046, 8'd7,  8'd1, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(logic [DW-1:0] d);
    res_valid = 1'b1; res_data = d;
    @(negedge clk);
    if (irq === 1'b1) irqs++;
    res_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg_rdata, 16'h0000);
    chk("R1 irq", irq, 0);
    chk("R1 mux", mux_sel_b, 0);
    chk("R1 scan", scan_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq idle", irq, 0);

    foreach (TBL[i]) begin
      automatic int iv = int'(TBL[i].cfg[7:4]) + 1;
      automatic int k = int'(TBL[i].n) - 1;
      automatic int pos = k % iv;
      automatic int addr = TBL[i].cfg[0] ? ((k / iv) % 2) * 8 + pos % 8 : pos;
      wr_cfg(TBL[i].cfg);
      irqs = 0;
      for (int j = 0; j < int'(TBL[i].n); j++) push(DW'(seq + j));
      // R3 interval count
      chk("R3 irq count", irqs, TBL[i].irqs);
      // R7 fill flag
      chk("R7 fill", cfg_rdata[8], TBL[i].fill);
      // R5 R6 placement of last result
      rd_addr = 4'(addr);
      #1;
      chk(TBL[i].cfg[0] ? "R6 addr" : "R5 addr", rd_data, DW'(seq + k));
      // R8 phase
      chk("R8 mux", mux_sel_b, TBL[i].cfg[1] ? (TBL[i].n % 2) : 0);
      // R9 scan
      chk("R9 scan", scan_req, TBL[i].cfg[2]);
      seq += 100;
      @(negedge clk);
    end

    // R2 register mask
    wr_cfg(16'hFFFF);
    chk("R2 readback", cfg_rdata, 16'h00F7);

    // R4 single-cycle pulse timing
    wr_cfg(16'h0010);
    push(12'h101);
    chk("R4 no irq mid", irq, 0);
    res_valid = 1'b1; res_data = 12'h102;
    @(negedge clk);
    res_valid = 1'b0;
    chk("R4 irq high", irq, 1);
    @(negedge clk);
    chk("R4 irq low", irq, 0);

    // R10 restart by reconfiguration
    wr_cfg(16'h0031);
    irqs = 0;
    push(12'h201); push(12'h202);
    wr_cfg(16'h0031);
    push(12'h211); push(12'h212); push(12'h213);
    chk("R10 no early irq", irqs, 0);
    push(12'h214);
    chk("R10 irq after restart", irqs, 1);
    rd_addr = 4'd0; #1;
    chk("R10 lower half restart", rd_data, 12'h211);

    // R10 colliding result discarded
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 16'h0010; res_valid = 1'b1; res_data = 12'h3AA;
    @(negedge clk);
    cfg_we = 1'b0; res_valid = 1'b0;
    irqs = 0;
    push(12'h301);
    chk("R10 collision dropped", irqs, 0);
    rd_addr = 4'd0; #1;
    chk("R10 collision data", rd_data, 12'h301);
    push(12'h302);
    chk("R10 irq on second", irqs, 1);

    // R6 wrap inside half
    wr_cfg(16'h0091);
    irqs = 0;
    for (int j = 0; j < 10; j++) push(12'h400 + 12'(j));
    chk("R6 irq", irqs, 1);
    rd_addr = 4'd0; #1;
    chk("R6 wrap addr0", rd_data, 12'h408);
    rd_addr = 4'd1; #1;
    chk("R6 wrap addr1", rd_data, 12'h409);
    chk("R7 upper after irq", cfg_rdata[8], 1);
    push(12'h4F0);
    rd_addr = 4'd8; #1;
    chk("R6 upper half", rd_data, 12'h4F0);

    // R7 linear reads zero
    wr_cfg(16'h0000);
    push(12'h500);
    chk("R7 linear fill", cfg_rdata[8], 0);

    // R8 alternation sequence
    wr_cfg(16'h00F2);
    chk("R8 start A", mux_sel_b, 0);
    push(12'h600);
    chk("R8 then B", mux_sel_b, 1);
    push(12'h601);
    chk("R8 back A", mux_sel_b, 0);
    wr_cfg(16'h00F0);
    push(12'h602);
    chk("R8 off stays A", mux_sel_b, 0);

    // R9 scan follows write
    wr_cfg(16'h0004);
    chk("R9 scan on", scan_req, 1);
    push(12'h700);
    chk("R9 scan held", scan_req, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule